// File: doc/BRIEF.md
# Key-Guarded Control Register Bank

This block is a small bank of system control registers on a plain single-cycle 32-bit bus. A request has a valid strobe, a write flag, a byte offset that is always word aligned, and write data. Read data and a rejection flag come back from registers one cycle after the request. The bank holds three kinds of register. There are PLL control words with a fixed non-zero reset value. There are PLL configuration words. There is a group of clock control words that reset to zero. A read-only PLL status word returns a fixed value.

Writes to anything at offset 0x100 or above are blocked while the bank is locked, and the bank comes out of reset locked. To open the bank, software writes a 16-bit release key to one offset. To close it again, software writes a different key to another offset. A read-only status word reports whether the bank is locked. A single scratch bit at offset 0x000 can be written at all times.

When a write is dropped, the block raises a one-cycle rejection pulse. A write is dropped when the bank is locked, when the target is read-only, or when the offset is not mapped. This pulse lets a surrounding agent or a bench see that the write did not take effect.

Top module: `keyed_ctrl_regs`

## Requirements
- R1: After reset the bank is locked. The status word (0x00C) reads 1. PLL control words at 0x100, 0x104 and 0x108 read 0x0001A008. PLL status (0x10C) reads 0x0000003F. PLL configuration words at 0x110, 0x114 and 0x118 read 0x00014000. Clock control words at 0x120 to 0x12C read 0. The scratch word at 0x000 reads 0.
- R2: A write to 0x008 whose data bits [15:0] equal 0xDF0D unlocks the bank, whatever the upper bits are. Any other value written there leaves the lock state unchanged and does not raise the rejection pulse.
- R3: A write to 0x004 whose data bits [15:0] equal 0x767B locks the bank, whatever the upper bits are. Any other value written there leaves the lock state unchanged and does not raise the rejection pulse.
- R4: Offset 0x00C reads 1 in bit 0 when locked and 0 when unlocked, with all other bits zero. A write to it changes nothing and raises the rejection pulse.
- R5: Offsets 0x004 and 0x008 always read as zero.
- R6: Offset 0x000 stores only bit 0 of the write data and reads the other bits as zero. It accepts writes in both lock states without a rejection pulse.
- R7: While locked, a write to any offset at or above 0x100 leaves every stored value unchanged and raises the rejection pulse.
- R8: While unlocked, a write to a PLL control, PLL configuration or clock control word stores all 32 bits. A later read returns that value, and no rejection pulse is raised.
- R9: The PLL status word at 0x10C ignores writes in both lock states, raises the rejection pulse, and keeps reading 0x0000003F.
- R10: An unmapped offset reads as zero. This includes misaligned offsets and the gap between 0x11C and 0x120. A write to an unmapped offset changes no stored value and raises the rejection pulse.
- R11: `rsp_rdata` and `rsp_err` reflect the request of the previous cycle. In a cycle after no request, or after a write, `rsp_rdata` is zero. `rsp_err` is high for exactly the one cycle after a rejected write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the previous cycle's read, else zero |
| rsp_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
A wrong lock state shows at the ports in two ways. It shows on the next write above 0x100, because the rejection pulse then appears when it should not, or fails to appear when it should. It also shows on any read of the status word, one cycle after the request. A corrupted stored word stays invisible until it is read back. For that reason the stimulus reads each word after every write class that could have touched it. A reference model compares both outputs in every cycle, so a fault is reported in the cycle right after the access that exposes it.

// File: rtl/keyed_ctrl_regs.sv
module keyed_ctrl_regs #(
  parameter int          ADDR_W       = 12,
  parameter int          N_PLL        = 3,
  parameter int          N_CLK        = 4,
  parameter int          CLK_BASE     = 'h120,
  parameter logic [15:0] LOCK_KEY     = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY   = 16'hDF0D,
  parameter logic [31:0] PLL_CTRL_RST = 32'h0001_A008,
  parameter logic [31:0] PLL_STAT_VAL = 32'h0000_003F,
  parameter logic [31:0] PLL_CFG_RST  = 32'h0001_4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int GUARD    = 'h100;
  localparam int STAT_OFS = GUARD + 4 * N_PLL;
  localparam int CFG_BASE = STAT_OFS + 4;

  typedef logic [ADDR_W-1:0] addr_t;

  logic        locked;
  logic        scratch;
  logic [31:0] pll_ctrl [N_PLL];
  logic [31:0] pll_cfg  [N_PLL];
  logic [31:0] clk_ctrl [N_CLK];
  logic [31:0] rd_val;

  logic [N_PLL-1:0] hit_ctrl;
  logic [N_PLL-1:0] hit_cfg;
  logic [N_CLK-1:0] hit_clk;

  wire wr = req_valid & req_write;
  wire rd = req_valid & ~req_write;

  wire hit_bit  = req_addr == addr_t'(0);
  wire hit_lk   = req_addr == addr_t'(4);
  wire hit_ul   = req_addr == addr_t'(8);
  wire hit_sta  = req_addr == addr_t'(12);
  wire hit_stat = req_addr == addr_t'(STAT_OFS);

  wire key_lock   = req_wdata[15:0] == LOCK_KEY;
  wire key_unlock = req_wdata[15:0] == UNLOCK_KEY;

  wire mapped    = hit_bit | hit_lk | hit_ul | hit_sta | hit_stat
                 | (|hit_ctrl) | (|hit_cfg) | (|hit_clk);
  wire above     = req_addr >= addr_t'(GUARD);
  wire read_only = hit_sta | hit_stat;
  wire reject    = wr & (~mapped | read_only | (locked & above));
  wire cfg_we    = wr & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   locked <= 1'b1;
    else if (wr && hit_lk && key_lock)   locked <= 1'b1;
    else if (wr && hit_ul && key_unlock) locked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              scratch <= 1'b0;
    else if (wr && hit_bit)  scratch <= req_wdata[0];
  end

  for (genvar g = 0; g < N_PLL; g++) begin : g_pll
    assign hit_ctrl[g] = req_addr == addr_t'(GUARD + 4 * g);
    assign hit_cfg[g]  = req_addr == addr_t'(CFG_BASE + 4 * g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     pll_ctrl[g] <= PLL_CTRL_RST;
      else if (cfg_we && hit_ctrl[g]) pll_ctrl[g] <= req_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    pll_cfg[g] <= PLL_CFG_RST;
      else if (cfg_we && hit_cfg[g]) pll_cfg[g] <= req_wdata;
    end
  end

  for (genvar g = 0; g < N_CLK; g++) begin : g_clk
    assign hit_clk[g] = req_addr == addr_t'(CLK_BASE + 4 * g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    clk_ctrl[g] <= '0;
      else if (cfg_we && hit_clk[g]) clk_ctrl[g] <= req_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_bit)  rd_val[0] = scratch;
    if (hit_sta)  rd_val[0] = locked;
    if (hit_stat) rd_val    = PLL_STAT_VAL;
    for (int i = 0; i < N_PLL; i++) begin
      if (hit_ctrl[i]) rd_val = rd_val | pll_ctrl[i];
      if (hit_cfg[i])  rd_val = rd_val | pll_cfg[i];
    end
    for (int i = 0; i < N_CLK; i++)
      if (hit_clk[i]) rd_val = rd_val | clk_ctrl[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= rd ? rd_val : '0;
      rsp_err   <= reject;
    end
  end
endmodule

// File: rtl/keyed_ctrl_regs_chk.sv
module keyed_ctrl_regs_chk #(
  parameter int          ADDR_W     = 12,
  parameter logic [15:0] LOCK_KEY   = 16'h767B,
  parameter logic [15:0] UNLOCK_KEY = 16'hDF0D
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              locked
);
  wire wr = req_valid & req_write;
  wire rd = req_valid & ~req_write;

  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == ADDR_W'(8) && req_wdata[15:0] == UNLOCK_KEY) |=> !locked);

  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == ADDR_W'(4) && req_wdata[15:0] == LOCK_KEY) |=> locked);

  p_lock_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (req_addr == ADDR_W'(4) || req_addr == ADDR_W'(8))) |=> $stable(locked));

  p_status_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && req_addr == ADDR_W'(12)) |=> rsp_rdata == {31'b0, $past(locked)});

  p_key_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (req_addr == ADDR_W'(4) || req_addr == ADDR_W'(8))) |=> rsp_rdata == 32'b0);

  p_locked_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && locked && req_addr >= ADDR_W'('h100)) |=> rsp_err);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (rsp_rdata == 32'b0 && !rsp_err));

  p_read_no_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rsp_err);
endmodule

bind keyed_ctrl_regs keyed_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .locked(locked)
);

// File: tb/test_keyed_ctrl_regs.sv
`timescale 1ns/1ps
module test_keyed_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  wire  [31:0] rsp_rdata;
  wire         rsp_err;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  keyed_ctrl_regs i_keyed_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] regs [int];
  logic        lock_m;
  logic [31:0] exp_rd;
  logic        exp_err;
  string       exp_tag;
  bit          live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      regs.delete();
      regs[0] = 0;
      for (int i = 0; i < 3; i++) begin
        regs['h100 + 4*i] = 32'h0001_A008;
        regs['h110 + 4*i] = 32'h0001_4000;
      end
      regs['h10C] = 32'h0000_003F;
      for (int i = 0; i < 4; i++) regs['h120 + 4*i] = 0;
      lock_m = 1; exp_rd = 0; exp_err = 0; exp_tag = "R1"; live = 0;
    end else begin
      int a;
      a = int'(req_addr);
      live = 1; exp_rd = 0; exp_err = 0;
      if (!req_valid) exp_tag = "R11";
      else if (!req_write) begin
        if (a == 'hC)                 begin exp_rd = {31'b0, lock_m}; exp_tag = "R4"; end
        else if (a == 4 || a == 8)    exp_tag = "R5";
        else if (regs.exists(a))      begin exp_rd = regs[a]; exp_tag = (a == 0) ? "R6" : (a == 'h10C) ? "R9" : "R8"; end
        else                          exp_tag = "R10";
      end else begin
        if (a == 4)                   begin exp_tag = "R3"; if (req_wdata[15:0] == 16'h767B) lock_m = 1; end
        else if (a == 8)              begin exp_tag = "R2"; if (req_wdata[15:0] == 16'hDF0D) lock_m = 0; end
        else if (a == 0)              begin exp_tag = "R6"; regs[0] = {31'b0, req_wdata[0]}; end
        else if (a == 'hC)            begin exp_tag = "R4"; exp_err = 1; end
        else if (a == 'h10C)          begin exp_tag = "R9"; exp_err = 1; end
        else if (!regs.exists(a))     begin exp_tag = "R10"; exp_err = 1; end
        else if (lock_m)              begin exp_tag = "R7"; exp_err = 1; end
        else                          begin exp_tag = "R8"; regs[a] = req_wdata; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && live) begin
      check({exp_tag, " model rdata"}, rsp_rdata, exp_rd);
      check({exp_tag, " model err"}, {31'b0, rsp_err}, {31'b0, exp_err});
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    check(tag, rsp_rdata, e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic e_err, input string tag);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
    check(tag, {31'b0, rsp_err}, {31'b0, e_err});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rsp_rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 err after reset", {31'b0, rsp_err}, 32'h0);
    rd('h00C, 32'h1, "R1 locked");
    rd('h100, 32'h0001_A008, "R1 pll ctrl0");
    rd('h104, 32'h0001_A008, "R1 pll ctrl1");
    rd('h108, 32'h0001_A008, "R1 pll ctrl2");
    rd('h10C, 32'h0000_003F, "R1 pll status");
    rd('h110, 32'h0001_4000, "R1 pll cfg0");
    rd('h118, 32'h0001_4000, "R1 pll cfg2");
    rd('h120, 32'h0, "R1 clk ctrl0");
    rd('h000, 32'h0, "R1 scratch");
    // locked writes
    wr('h100, 32'h1234_5678, 1, "R7 locked write err");
    rd('h100, 32'h0001_A008, "R7 locked write kept");
    wr('h12C, 32'hFFFF_FFFF, 1, "R7 locked clk write err");
    rd('h12C, 32'h0, "R7 locked clk kept");
    wr('h000, 32'hFFFF_FFFF, 0, "R6 scratch while locked");
    rd('h000, 32'h1, "R6 scratch bit only");
    // wrong and right unlock key
    wr('h008, 32'h0000_1234, 0, "R2 wrong key no err");
    rd('h00C, 32'h1, "R2 still locked");
    wr('h008, 32'hABCD_DF0D, 0, "R2 unlock");
    rd('h00C, 32'h0, "R2 unlocked");
    rd('h004, 32'h0, "R5 lock reads zero");
    rd('h008, 32'h0, "R5 unlock reads zero");
    // unlocked writes
    wr('h104, 32'hCAFE_F00D, 0, "R8 write ctrl1");
    rd('h104, 32'hCAFE_F00D, "R8 ctrl1 back");
    wr('h114, 32'h0BAD_BEEF, 0, "R8 write cfg1");
    rd('h114, 32'h0BAD_BEEF, "R8 cfg1 back");
    wr('h12C, 32'h5A5A_5A5A, 0, "R8 write clk3");
    rd('h12C, 32'h5A5A_5A5A, "R8 clk3 back");
    wr('h000, 32'hFFFF_FFFE, 0, "R6 scratch clear");
    rd('h000, 32'h0, "R6 scratch cleared");
    wr('h10C, 32'h0, 1, "R9 status write err");
    rd('h10C, 32'h0000_003F, "R9 status kept");
    wr('h00C, 32'h1, 1, "R4 lock status write err");
    rd('h00C, 32'h0, "R4 still unlocked");
    // unmapped
    wr('h200, 32'hDEAD_BEEF, 1, "R10 unmapped write err");
    rd('h200, 32'h0, "R10 unmapped read");
    wr('h11C, 32'hDEAD_BEEF, 1, "R10 gap write err");
    rd('h11C, 32'h0, "R10 gap read");
    rd('h106, 32'h0, "R10 misaligned read");
    wr('h010, 32'h1, 1, "R10 low unmapped write err");
    rd('h104, 32'hCAFE_F00D, "R10 neighbour intact");
    // relock
    wr('h004, 32'h0000_767A, 0, "R3 wrong key no err");
    rd('h00C, 32'h0, "R3 still unlocked");
    wr('h004, 32'hFFFF_767B, 0, "R3 lock");
    rd('h00C, 32'h1, "R3 locked again");
    wr('h104, 32'h0, 1, "R7 relocked write err");
    rd('h104, 32'hCAFE_F00D, "R7 relocked kept");
    // back-to-back traffic and idle behaviour
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 'h120; req_wdata = 32'h1;
    @(negedge clk); req_write = 0; req_addr = 'h10C;
    check("R11 err after locked write", {31'b0, rsp_err}, 32'h1);
    @(negedge clk); req_valid = 0;
    check("R11 read after write", rsp_rdata, 32'h0000_003F);
    check("R11 err cleared", {31'b0, rsp_err}, 32'h0);
    @(negedge clk);
    check("R11 idle rdata", rsp_rdata, 32'h0);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule